// File: doc/BRIEF.md
# Snapshot Statistics Counter Bank

This block keeps a bank of event counters for a 10 Gb/s Ethernet MAC. The first few counters accumulate byte counts (up to 16 bytes per clock) and the rest count single-cycle frame events such as unicast, multicast, broadcast, pause, FCS-error, jabber, fragment and jumbo frames. Event classification happens elsewhere. This block only adds what it is given.

Software reads the bank through a 16-bit register port with one-cycle read latency. A snapshot command copies every live counter into a shadow copy in the same clock, and all counter reads return the shadow copy. This gives software one consistent set of values, even though each counter takes three reads. Each counter has a sticky wrap flag. The flags are grouped sixteen to a register and are cleared by reading that register. A per-flag mask drives a single interrupt line, so software can poll with all masks at zero. A clear command zeroes the counters, the shadows and the flags.

Top module: `stat_bank`

## Requirements
- R1: Counter i is read at address 16+4*i. Offset 0 returns bits 15:0 of its shadow, offset 1 returns bits 31:16, and offset 2 returns bits 39:32 in data bits 7:0 with the upper byte zero. Offset 3, the control address 0 and every unmapped address read as zero. Read data appears in the cycle after the read strobe and holds until the next read.
- R2: Writing address 0 with data bit 0 set copies every live counter into its shadow at that clock edge. Counter reads return only shadow values, so increments are invisible until the next snapshot.
- R3: When a counter increments in the same cycle as a snapshot, the shadow gets the value before the increment and the live counter keeps the increment.
- R4: Writing address 0 with data bit 1 set zeroes all live counters, shadows and wrap flags in one clock. In that cycle it overrides any increment, wrap or snapshot.
- R5: The wrap flag of counter i sets when the counter carries past 2^CNT_W. It is bit i%16 of the flag register at address 4+i/16, and it stays set until cleared.
- R6: A read of a flag register returns its flags and clears them at the same edge. A flag that sets in that same cycle stays set.
- R7: Mask register k sits at address 8+k and is read/write, with reset value zero. The irq output is high in the cycle after any flag whose mask bit is 1 is set, and it stays low while the masks hide every set flag.
- R8: Byte counters (indices below NUM_OCT) add their 5-bit byte count (0 to 16) each cycle. Frame counters add 1 for each cycle their strobe is high.
- R9: After reset every counter, shadow, flag and mask is zero, read data is zero and irq is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| oct_bytes_i | input | NUM_OCT*5 | Per-cycle byte count for each byte counter, 5 bits each, lowest counter in the low bits |
| frm_evt_i | input | NUM_CNT-NUM_OCT | One-cycle frame event strobes for counters NUM_OCT and up |
| reg_wr_i | input | 1 | Register write strobe |
| reg_rd_i | input | 1 | Register read strobe |
| reg_addr_i | input | ADDR_W | Register word address |
| reg_wdata_i | input | 16 | Write data |
| reg_rdata_o | output | 16 | Read data, valid the cycle after reg_rd_i |
| irq_o | output | 1 | Masked wrap interrupt |

## Verification
Read data is due one cycle after the read strobe. A snapshot or clear written in cycle t is visible to a read issued in cycle t+1, and irq follows the flag and mask state one cycle later. The bench drives inputs just after each rising edge and advances a behavioural model of the counters, shadows, flags and masks at that edge. It compares read data and irq at the following falling edge, so every comparison lands exactly when the result is due. Directed reads pin down the snapshot-coincident increment, the slice layout and the wrap on a reduced counter width. They also cover a flag that sets during its own clear-on-read and a clear that meets live events.

// File: rtl/stat_pkg.sv
package stat_pkg;
   // register map (word addresses)
   localparam int CTRL_ADDR  = 0;
   localparam int ROLL_BASE  = 4;
   localparam int MASK_BASE  = 8;
   localparam int CNT_BASE   = 16;
   localparam int CNT_STRIDE = 4;
   localparam int MAX_FLAG_REGS = 4;

   // control register bits
   localparam int SNAP_BIT = 0;
   localparam int CLR_BIT  = 1;

   // byte counter increment
   localparam int BYTE_W    = 5;
   localparam int MAX_BYTES = 16;

   typedef enum logic [1:0] {
      SL_LO  = 2'd0,
      SL_MID = 2'd1,
      SL_HI  = 2'd2,
      SL_PAD = 2'd3
   } slice_e;

   function automatic logic [15:0] slice16(input logic [47:0] v, input slice_e s);
      logic [15:0] r;
      case (s)
         SL_LO:   r = v[15:0];
         SL_MID:  r = v[31:16];
         SL_HI:   r = {8'h00, v[39:32]};
         default: r = 16'h0000;
      endcase
      return r;
   endfunction
endpackage

// File: rtl/stat_counter.sv
module stat_counter
   import stat_pkg::*;
#(
   parameter int CNT_W    = 40,
   parameter int INC_W    = 5,
   parameter bit IS_OCTET = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [INC_W-1:0] inc_i,
   input  logic             snap_i,
   input  logic             clr_i,
   output logic [CNT_W-1:0] shadow_o,
   output logic             wrap_o
);
   logic [CNT_W-1:0] live_q;
   logic [CNT_W-1:0] shadow_q;
   logic [CNT_W-1:0] step;
   logic [CNT_W:0]   sum;

   initial begin
      assert (CNT_W > INC_W && CNT_W <= 40)
         else $fatal(1, "stat_counter: CNT_W out of range");
   end

   generate
      if (IS_OCTET) begin : g_octet
         always_comb step = CNT_W'(inc_i);
         // byte count never exceeds one 16-byte beat (R8)
         assert_byte_limit_R8: assert property (@(posedge clk) disable iff (!rst_n)
            inc_i <= INC_W'(MAX_BYTES));
      end else begin : g_frame
         always_comb step = CNT_W'(inc_i[0]);
         // a frame counter moves by at most one per cycle (R8)
         assert_frame_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
            !clr_i |=> (live_q - $past(live_q)) <= CNT_W'(1));
      end
   endgenerate

   assign sum    = {1'b0, live_q} + {1'b0, step};
   assign wrap_o = sum[CNT_W];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         live_q   <= '0;
         shadow_q <= '0;
      end else if (clr_i) begin
         live_q   <= '0;
         shadow_q <= '0;
      end else begin
         live_q <= sum[CNT_W-1:0];
         if (snap_i) shadow_q <= live_q;
      end
   end

   assign shadow_o = shadow_q;

   assert_snap_pre_inc_R3: assert property (@(posedge clk) disable iff (!rst_n)
      snap_i && !clr_i |=> shadow_q == $past(live_q));

   assert_shadow_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !snap_i && !clr_i |=> $stable(shadow_q));

   assert_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
      clr_i |=> live_q == '0 && shadow_q == '0);
endmodule

// File: rtl/stat_roll.sv
module stat_roll #(
   parameter int NUM_CNT = 32,
   parameter int NUM_REG = 2
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [NUM_CNT-1:0]    wrap_i,
   input  logic                  clr_i,
   input  logic [NUM_REG-1:0]    rd_sel_i,
   output logic [NUM_REG*16-1:0] flags_o
);
   localparam int FLAG_N = NUM_REG * 16;

   logic [FLAG_N-1:0] flag_q;
   logic [FLAG_N-1:0] wrap_ext;
   logic [FLAG_N-1:0] rd_mask;

   initial begin
      assert (FLAG_N >= NUM_CNT && FLAG_N - NUM_CNT < 16)
         else $fatal(1, "stat_roll: NUM_REG does not fit NUM_CNT");
   end

   assign wrap_ext = FLAG_N'(wrap_i);

   generate
      for (genvar r = 0; r < NUM_REG; r++) begin : g_sel
         assign rd_mask[r*16 +: 16] = {16{rd_sel_i[r]}};
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     flag_q <= '0;
      else if (clr_i) flag_q <= '0;
      else            flag_q <= (flag_q & ~rd_mask) | wrap_ext;
   end

   assign flags_o = flag_q;

   assert_wrap_sets_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !clr_i |=> (($past(wrap_ext) & ~flag_q) == '0));

   assert_clear_by_read_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !clr_i |=> (($past(flag_q) & ~flag_q & ~$past(rd_mask)) == '0));

   assert_one_reg_read_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(rd_sel_i));
endmodule

// File: rtl/stat_regif.sv
module stat_regif
   import stat_pkg::*;
#(
   parameter int NUM_CNT = 32,
   parameter int CNT_W   = 40,
   parameter int ADDR_W  = 8,
   parameter int NUM_REG = 2
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     reg_wr_i,
   input  logic                     reg_rd_i,
   input  logic [ADDR_W-1:0]        reg_addr_i,
   input  logic [15:0]              reg_wdata_i,
   input  logic [NUM_CNT*CNT_W-1:0] shadow_i,
   input  logic [NUM_REG*16-1:0]    flags_i,
   output logic                     snap_o,
   output logic                     clr_o,
   output logic [NUM_REG-1:0]       roll_rd_o,
   output logic [15:0]              rdata_o,
   output logic                     irq_o
);
   logic [NUM_REG*16-1:0] mask_q;
   logic [NUM_REG-1:0]    roll_hit;
   logic [NUM_REG-1:0]    mask_hit;
   logic [15:0]           rd_val;
   logic [15:0]           rdata_q;
   logic                  irq_q;
   logic                  ctrl_hit;

   initial begin
      assert (CNT_BASE + CNT_STRIDE * NUM_CNT <= (1 << ADDR_W))
         else $fatal(1, "stat_regif: ADDR_W too small for NUM_CNT");
      assert (NUM_REG <= MAX_FLAG_REGS)
         else $fatal(1, "stat_regif: too many flag registers");
   end

   assign ctrl_hit = (reg_addr_i == ADDR_W'(CTRL_ADDR));
   assign snap_o   = reg_wr_i && ctrl_hit && reg_wdata_i[SNAP_BIT];
   assign clr_o    = reg_wr_i && ctrl_hit && reg_wdata_i[CLR_BIT];

   generate
      for (genvar r = 0; r < NUM_REG; r++) begin : g_dec
         assign roll_hit[r] = (reg_addr_i == ADDR_W'(ROLL_BASE + r));
         assign mask_hit[r] = (reg_addr_i == ADDR_W'(MASK_BASE + r));
      end
   endgenerate

   assign roll_rd_o = roll_hit & {NUM_REG{reg_rd_i}};

   always_comb begin
      rd_val = 16'h0000;
      for (int r = 0; r < NUM_REG; r++) begin
         if (roll_hit[r]) rd_val = flags_i[r*16 +: 16];
         if (mask_hit[r]) rd_val = mask_q[r*16 +: 16];
      end
      for (int i = 0; i < NUM_CNT; i++) begin
         for (int s = 0; s < 3; s++) begin
            if (reg_addr_i == ADDR_W'(CNT_BASE + CNT_STRIDE * i + s))
               rd_val = slice16(48'(shadow_i[i*CNT_W +: CNT_W]), slice_e'(s));
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mask_q  <= '0;
         rdata_q <= '0;
         irq_q   <= 1'b0;
      end else begin
         for (int r = 0; r < NUM_REG; r++)
            if (reg_wr_i && mask_hit[r]) mask_q[r*16 +: 16] <= reg_wdata_i;
         if (reg_rd_i) rdata_q <= rd_val;
         irq_q <= |(flags_i & mask_q);
      end
   end

   assign rdata_o = rdata_q;
   assign irq_o   = irq_q;

   assert_rdata_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !reg_rd_i |=> $stable(rdata_q));

   assert_irq_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq_q) |-> $past(|(flags_i & mask_q)));

   assert_irq_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (flags_i & mask_q) == '0 |=> !irq_q);
endmodule

// File: rtl/stat_bank.sv
module stat_bank
   import stat_pkg::*;
#(
   parameter int NUM_CNT = 32,
   parameter int NUM_OCT = 4,
   parameter int CNT_W   = 40,
   parameter int ADDR_W  = 8
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic [NUM_OCT*BYTE_W-1:0]     oct_bytes_i,
   input  logic [NUM_CNT-NUM_OCT-1:0]    frm_evt_i,
   input  logic                          reg_wr_i,
   input  logic                          reg_rd_i,
   input  logic [ADDR_W-1:0]             reg_addr_i,
   input  logic [15:0]                   reg_wdata_i,
   output logic [15:0]                   reg_rdata_o,
   output logic                          irq_o
);
   localparam int NUM_FRM = NUM_CNT - NUM_OCT;
   localparam int NUM_REG = (NUM_CNT + 15) / 16;

   logic [NUM_CNT*CNT_W-1:0] shadow_flat;
   logic [NUM_CNT-1:0]       wrap;
   logic [NUM_REG*16-1:0]    flags;
   logic [NUM_REG-1:0]       roll_rd;
   logic                     snap;
   logic                     clr;

   initial begin
      assert (NUM_CNT >= 2 && NUM_CNT <= 16 * MAX_FLAG_REGS)
         else $fatal(1, "stat_bank: NUM_CNT out of range");
      assert (NUM_OCT >= 1 && NUM_FRM >= 1)
         else $fatal(1, "stat_bank: need byte and frame counters");
   end

   generate
      for (genvar g = 0; g < NUM_CNT; g++) begin : g_cnt
         if (g < NUM_OCT) begin : g_oct
            stat_counter #(.CNT_W(CNT_W), .INC_W(BYTE_W), .IS_OCTET(1'b1)) u_cnt (
               .clk      (clk),
               .rst_n    (rst_n),
               .inc_i    (oct_bytes_i[g*BYTE_W +: BYTE_W]),
               .snap_i   (snap),
               .clr_i    (clr),
               .shadow_o (shadow_flat[g*CNT_W +: CNT_W]),
               .wrap_o   (wrap[g])
            );
         end else begin : g_frm
            stat_counter #(.CNT_W(CNT_W), .INC_W(1), .IS_OCTET(1'b0)) u_cnt (
               .clk      (clk),
               .rst_n    (rst_n),
               .inc_i    (frm_evt_i[g-NUM_OCT]),
               .snap_i   (snap),
               .clr_i    (clr),
               .shadow_o (shadow_flat[g*CNT_W +: CNT_W]),
               .wrap_o   (wrap[g])
            );
         end
      end
   endgenerate

   stat_roll #(.NUM_CNT(NUM_CNT), .NUM_REG(NUM_REG)) u_roll (
      .clk      (clk),
      .rst_n    (rst_n),
      .wrap_i   (wrap),
      .clr_i    (clr),
      .rd_sel_i (roll_rd),
      .flags_o  (flags)
   );

   stat_regif #(.NUM_CNT(NUM_CNT), .CNT_W(CNT_W), .ADDR_W(ADDR_W), .NUM_REG(NUM_REG)) u_regif (
      .clk         (clk),
      .rst_n       (rst_n),
      .reg_wr_i    (reg_wr_i),
      .reg_rd_i    (reg_rd_i),
      .reg_addr_i  (reg_addr_i),
      .reg_wdata_i (reg_wdata_i),
      .shadow_i    (shadow_flat),
      .flags_i     (flags),
      .snap_o      (snap),
      .clr_o       (clr),
      .roll_rd_o   (roll_rd),
      .rdata_o     (reg_rdata_o),
      .irq_o       (irq_o)
   );
endmodule

// File: tb/stat_bank_tb.sv
module stat_bank_tb;
   localparam int NUM_CNT = 8;
   localparam int NUM_OCT = 2;
   localparam int NUM_FRM = NUM_CNT - NUM_OCT;
   localparam int CNT_W   = 18;
   localparam int ADDR_W  = 8;
   localparam longint WRAP = 64'd1 << CNT_W;

   logic clk = 1'b0;
   always #2 clk = ~clk;

   logic                  rst_n = 1'b0;
   logic [NUM_OCT*5-1:0]  oct_bytes = '0;
   logic [NUM_FRM-1:0]    frm_evt = '0;
   logic                  reg_wr = 1'b0;
   logic                  reg_rd = 1'b0;
   logic [ADDR_W-1:0]     reg_addr = '0;
   logic [15:0]           reg_wdata = '0;
   logic [15:0]           reg_rdata;
   logic                  irq;

   stat_bank #(.NUM_CNT(NUM_CNT), .NUM_OCT(NUM_OCT), .CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_dut (
      .clk(clk), .rst_n(rst_n), .oct_bytes_i(oct_bytes), .frm_evt_i(frm_evt),
      .reg_wr_i(reg_wr), .reg_rd_i(reg_rd), .reg_addr_i(reg_addr),
      .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata), .irq_o(irq)
   );

   // behavioural model
   logic [63:0] m_live [NUM_CNT];
   logic [63:0] m_shad [NUM_CNT];
   logic [15:0] m_flags = '0;
   logic [15:0] m_mask  = '0;
   logic [15:0] m_rdata = '0;
   logic        m_irq   = 1'b0;
   string       m_tag   = "R9";
   int vectors = 0;
   int miscompares = 0;
   int cycles = 0;
   bit started = 1'b0;
   bit done = 1'b0;

   initial for (int i = 0; i < NUM_CNT; i++) begin m_live[i] = 0; m_shad[i] = 0; end

   function automatic logic [15:0] m_read(input logic [ADDR_W-1:0] a);
      int ai = int'(a);
      if (ai >= 16 && ai < 16 + 4 * NUM_CNT) begin
         int idx = (ai - 16) / 4;
         int sl  = (ai - 16) % 4;
         logic [63:0] v = m_shad[idx];
         if (sl == 0) return v[15:0];
         if (sl == 1) return v[31:16];
         if (sl == 2) return {8'h00, v[39:32]};
         return 16'h0000;
      end
      if (ai == 4) return m_flags;
      if (ai == 8) return m_mask;
      return 16'h0000;
   endfunction

   always @(posedge clk or negedge rst_n) begin : model
      logic [15:0] wraps;
      logic [15:0] rdclr;
      logic        irq_n;
      logic [63:0] inc;
      logic [63:0] sum;
      if (!rst_n) begin
         for (int i = 0; i < NUM_CNT; i++) begin m_live[i] = 0; m_shad[i] = 0; end
         m_flags = 0; m_mask = 0; m_rdata = 0; m_irq = 0; m_tag = "R9";
      end else begin
         wraps = 0; rdclr = 0;
         irq_n = |(m_flags & m_mask);
         if (reg_rd) begin
            m_rdata = m_read(reg_addr);
            if (reg_addr == 4) begin rdclr = 16'hffff; m_tag = "R6"; end
            else if (reg_addr == 8) m_tag = "R7";
            else if (reg_addr >= 16) m_tag = "R2";
            else m_tag = "R1";
         end
         if (reg_wr && reg_addr == 0 && reg_wdata[1]) begin
            for (int i = 0; i < NUM_CNT; i++) begin m_live[i] = 0; m_shad[i] = 0; end
            m_flags = 0;
         end else begin
            for (int i = 0; i < NUM_CNT; i++) begin
               inc = (i < NUM_OCT) ? 64'(oct_bytes[i*5 +: 5]) : 64'(frm_evt[i-NUM_OCT]);
               sum = m_live[i] + inc;
               if (sum >= WRAP) begin wraps[i] = 1'b1; sum = sum - WRAP; end
               if (reg_wr && reg_addr == 0 && reg_wdata[0]) m_shad[i] = m_live[i];
               m_live[i] = sum;
            end
            m_flags = (m_flags & ~rdclr) | wraps;
         end
         if (reg_wr && reg_addr == 8) m_mask = reg_wdata;
         m_irq = irq_n;
      end
   end

   // per-cycle comparison on the falling edge
   always @(negedge clk) begin
      cycles++;
      if (started && !done) begin
         vectors++;
         if (reg_rdata !== m_rdata || irq !== m_irq) begin
            miscompares++;
            if (reg_rdata !== m_rdata)
               $display("FAIL %s rdata got %h exp %h (cycle %0d)", m_tag, reg_rdata, m_rdata, cycles);
            else
               $display("FAIL R7 irq got %b exp %b (cycle %0d)", irq, m_irq, cycles);
         end
      end
      if (cycles > 150000 && !done) begin
         done = 1'b1;
         miscompares++;
         $display("FAIL watchdog expired got %0d cycles exp completion", cycles);
         $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
         $finish;
      end
   end

   task automatic step();
      @(posedge clk); #1;
      reg_wr = 0; reg_rd = 0; oct_bytes = '0; frm_evt = '0;
   endtask

   task automatic wr(input int a, input logic [15:0] d);
      reg_wr = 1; reg_addr = ADDR_W'(a); reg_wdata = d; step();
   endtask

   task automatic rd(input int a);
      reg_rd = 1; reg_addr = ADDR_W'(a); step();
   endtask

   task automatic chk(input string tag, input logic [15:0] got, input logic [15:0] exp);
      vectors++;
      if (got !== exp) begin
         miscompares++;
         $display("FAIL %s got %h exp %h", tag, got, exp);
      end
   endtask

   task automatic rd_chk(input string tag, input int a, input logic [15:0] exp);
      rd(a);
      chk(tag, reg_rdata, exp);
   endtask

   initial begin
      repeat (3) @(posedge clk);
      #1 started = 1'b1;
      chk("R9 reset rdata", reg_rdata, 16'h0000);
      chk("R9 reset irq", {15'h0, irq}, 16'h0000);
      rst_n = 1'b1;
      step();
      rd_chk("R9 flags after reset", 4, 16'h0000);
      rd_chk("R9 mask after reset", 8, 16'h0000);

      // frame and byte traffic
      for (int k = 0; k < 5; k++) begin frm_evt[0] = 1; if (k < 3) frm_evt[5] = 1; step(); end
      oct_bytes[4:0] = 16; step();
      oct_bytes[4:0] = 7;  step();
      oct_bytes[4:0] = 1;  oct_bytes[9:5] = 9; step();
      rd_chk("R2 no snap yet", 16 + 4*2, 16'h0000);
      wr(0, 16'h0001);
      rd_chk("R8 frame count", 16 + 4*2, 16'd5);
      rd_chk("R8 byte count", 16, 16'd24);
      rd_chk("R8 second byte count", 16 + 4*1, 16'd9);
      rd_chk("R8 last frame count", 16 + 4*7, 16'd3);

      // increment coincident with snapshot
      frm_evt[0] = 1; reg_wr = 1; reg_addr = 0; reg_wdata = 16'h0001; step();
      rd_chk("R3 shadow pre-increment", 16 + 4*2, 16'd5);
      wr(0, 16'h0001);
      rd_chk("R3 increment kept", 16 + 4*2, 16'd6);

      // slice layout: 24 + 16*8200 = 131224 = 0x20098
      wr(8, 16'h0001);
      for (int k = 0; k < 8200; k++) begin oct_bytes[4:0] = 16; step(); end
      wr(0, 16'h0001);
      rd_chk("R1 low slice", 16, 16'h0098);
      rd_chk("R1 mid slice", 17, 16'h0002);
      rd_chk("R1 high slice", 18, 16'h0000);
      rd_chk("R1 pad offset", 19, 16'h0000);
      rd_chk("R1 control reads zero", 0, 16'h0000);
      rd_chk("R1 unmapped reads zero", 12, 16'h0000);
      chk("R7 irq idle", {15'h0, irq}, 16'h0000);

      // wrap of counter 0: 131224 + 131200 = 262424 -> 280
      for (int k = 0; k < 8200; k++) begin oct_bytes[4:0] = 16; step(); end
      step();
      chk("R7 irq on masked-in flag", {15'h0, irq}, 16'h0001);
      rd_chk("R5 wrap flag", 4, 16'h0001);
      rd_chk("R6 flag cleared by read", 4, 16'h0000);
      chk("R7 irq drops", {15'h0, irq}, 16'h0000);
      wr(0, 16'h0001);
      rd_chk("R5 wrapped value", 16, 16'd280);

      // counter 1: 9 + 16*16383 = 262137, next 16 wraps during flag read
      for (int k = 0; k < 16383; k++) begin oct_bytes[9:5] = 16; step(); end
      oct_bytes[9:5] = 16; reg_rd = 1; reg_addr = 4; step();
      chk("R6 read during wrap", reg_rdata, 16'h0000);
      rd_chk("R6 coincident flag kept", 4, 16'h0002);
      chk("R7 masked flag no irq", {15'h0, irq}, 16'h0000);

      // clear with live events and a pending flag
      oct_bytes[4:0] = 16; step(); step();
      frm_evt = '1; oct_bytes = {5'd16, 5'd16};
      reg_wr = 1; reg_addr = 0; reg_wdata = 16'h0003; step();
      rd_chk("R4 flags cleared", 4, 16'h0000);
      rd_chk("R4 shadow cleared", 16 + 4*2, 16'h0000);
      wr(0, 16'h0001);
      rd_chk("R4 live cleared", 16 + 4*3, 16'h0000);
      rd_chk("R4 byte counter cleared", 16, 16'h0000);

      // mixed traffic against the model
      wr(8, 16'h00ff);
      for (int k = 0; k < 3000; k++) begin
         int pick;
         frm_evt = NUM_FRM'($urandom);
         oct_bytes = {5'($urandom_range(16, 0)), 5'($urandom_range(16, 0))};
         pick = int'($urandom_range(9, 0));
         if (pick < 5) begin
            reg_rd = 1;
            reg_addr = ADDR_W'((pick == 0) ? 4 : 16 + $urandom_range(4*NUM_CNT - 1, 0));
         end else if (pick == 5) begin
            reg_wr = 1; reg_addr = 0; reg_wdata = 16'h0001;
         end else if (pick == 6 && $urandom_range(40, 0) == 0) begin
            reg_wr = 1; reg_addr = 0; reg_wdata = 16'h0002;
         end else if (pick == 7) begin
            reg_wr = 1; reg_addr = 8; reg_wdata = 16'($urandom);
         end
         step();
      end
      step();
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end
endmodule